// File: doc/BRIEF.md
# Two-Channel Chained Breakpoint Comparator

This block watches a stream of bus events, one per clock, and compares each against two programmable match channels. Each channel holds a compare address and a cycle kind, either instruction fetch or operand access. A matching channel records the hit in a sticky flag that software clears by writing ones. A channel can raise a break on its own. It can also be chained, so that it breaks only after the other channel has already matched. The chain works in either order, channel 0 then channel 1, or channel 1 then channel 0.

The channel that comes first in a chain is set up with chaining off and its break enable off, so it never breaks by itself. Its flag then serves as the arming state. The channel that comes second has chaining on and names the other channel as its source. To make the spacing between the two hits deterministic, the source flag reaches the chain check only after one extra registered cycle. Channel 1 can also be made to count its hits down from a loaded value, and it counts as satisfied only on the hit that brings the count to zero. The break request is a registered pulse.

Top module: `seqbrk_unit`

## Requirements
- R1: After reset both match flags and the break request read 0, and no channel is enabled, so no event can set a flag.
- R2: A channel hits when `ev_valid` is 1, its enable is 1, `ev_addr` equals its compare address, and `ev_kind` equals its kind (0 = instruction fetch, 1 = operand access). Register selects: 0 and 2 hold the address of channel 0 and channel 1 (low AW bits of `wr_data`). 1 and 3 hold control, with bit0 enable, bit1 kind, bit2 chain enable, bit3 chain source channel, bit4 break enable and bit5 count enable.
- R3: A channel's flag (`match_flag[c]`) is 1 in the cycle after every satisfied match, chained or not. It then stays 1 until it is cleared.
- R4: Writing select 5 clears flag c for each bit c of `wr_data[1:0]` that is 1. If a clear and a satisfied match of the same channel fall in the same cycle, the flag stays 1.
- R5: A channel with chaining off and break enable on makes `brk_req` 1 for exactly the one cycle after each satisfied match.
- R6: A channel with chaining on and break enable on breaks only if its source channel's flag was armed before its own match. This works in both orders, 0 then 1 and 1 then 0, and every further match while the source stays armed breaks again.
- R7: The chain holds only when the second channel's match is at least two cycles after the first channel's match. A match in the same cycle or in the next cycle sets the flag but does not break. This rule applies for fetch/fetch and for fetch/operand pairs alike.
- R8: Clearing the first channel's flag disarms the chain. A second-channel match in the same cycle as that clear does not break, and neither does any later one.
- R9: Writing select 4 loads the channel-1 counter from the low CNT_W bits of `wr_data`. With count enable set, each channel-1 hit decrements a nonzero count. The channel is satisfied only on the hit taken while the count is 1. At zero the count holds, and no further hit satisfies the channel. A load in the same cycle as a hit wins over the decrement, but that hit is still judged on the old count. Bit5 has no effect on channel 0.
- R10: A chained channel whose source field names itself never breaks.
- R11: A register write takes effect from the next cycle. An event in the same cycle as the write is compared against the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0..5) |
| wr_data | input | DW | Write data |
| ev_valid | input | 1 | Bus event present this cycle |
| ev_addr | input | AW | Event address |
| ev_kind | input | 1 | Event kind, 0 fetch, 1 operand |
| match_flag | output | 2 | Sticky per-channel match flags |
| brk_req | output | 1 | Registered break request pulse |

## Verification
The bench builds the block with AW=12, CNT_W=4 and DW=16. The narrow counter brings the count-to-zero hit, the spent state at zero and the load-versus-hit collision within a few events. The short address keeps the write data small. A behavioural model tracks how long each flag has been set, and the bench compares flags and the break pulse with it on every clock. The model is driven through both chain orders, hit gaps of zero, one and two cycles, disarming clears, a self-naming chain source and the counter sequence.

// File: rtl/seqbrk_pkg.sv
package seqbrk_pkg;

    typedef enum logic {
        KIND_FETCH = 1'b0,
        KIND_OPER  = 1'b1
    } kind_e;

    // Packed so that bit 0 of the control word is the enable.
    typedef struct packed {
        logic  cnt_en;
        logic  brk_en;
        logic  chain_src;
        logic  chain_en;
        kind_e kind;
        logic  en;
    } chan_cfg_t;

    localparam int          SEL_W   = 3;
    localparam int          CFG_W   = 6;
    localparam logic [2:0]  SEL_CNT = 3'd4;
    localparam logic [2:0]  SEL_CLR = 3'd5;

endpackage

// File: rtl/seqbrk_chan.sv
module seqbrk_chan
    import seqbrk_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CH      = 0,
    parameter bit HAS_CNT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]    wr_addr,
    input  chan_cfg_t        wr_cfg,
    input  logic             ev_valid,
    input  logic [AW-1:0]    ev_addr,
    input  logic             ev_kind,
    output chan_cfg_t        cfg,
    output logic             hit
);

    localparam logic [SEL_W-1:0] SEL_ADDR = SEL_W'(2 * CH);
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(2 * CH + 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        chan_cfg_t     cfg;
    } chan_st_t;

    chan_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && wr_sel == SEL_ADDR) begin
            s_d.addr = wr_addr;
        end
        if (wr_en && wr_sel == SEL_CTRL) begin
            s_d.cfg = wr_cfg;
            if (!HAS_CNT) begin
                s_d.cfg.cnt_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg = s_q.cfg;
    assign hit = ev_valid & s_q.cfg.en & (ev_addr == s_q.addr)
               & (kind_e'(ev_kind) == s_q.cfg.kind);

    assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_CTRL) |=> $stable(s_q.cfg));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_ADDR) |=> $stable(s_q.addr));

    generate
        if (!HAS_CNT) begin : g_nocnt
            assert_no_count_ch0_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !s_q.cfg.cnt_en);
        end
    endgenerate

endmodule

// File: rtl/seqbrk_count.sv
module seqbrk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = load_val;
        end else if (step && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Judged on the count held before the edge.
    assign fire = step & (s_q.cnt == ONE);

    assert_cnt_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (s_q.cnt <= $past(s_q.cnt)));

    assert_cnt_zero_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && s_q.cnt == '0) |=> (s_q.cnt == '0));

    assert_cnt_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (s_q.cnt == $past(load_val)));

endmodule

// File: rtl/seqbrk_unit.sv
module seqbrk_unit
    import seqbrk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             ev_valid,
    input  logic [AW-1:0]    ev_addr,
    input  logic             ev_kind,
    output logic [1:0]       match_flag,
    output logic             brk_req
);

    localparam int NCH = 2;

    typedef struct packed {
        logic [NCH-1:0] flag;
        logic [NCH-1:0] arm;
        logic           brk;
    } top_st_t;

    top_st_t        s_d, s_q;
    chan_cfg_t      cfg [NCH];
    logic [NCH-1:0] hit;
    logic [NCH-1:0] sat;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] link;
    logic [NCH-1:0] brk_ch;
    logic           cnt_fire;
    logic           unused_wr;

    assign unused_wr = ^wr_data;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            seqbrk_chan #(
                .AW      (AW),
                .CH      (c),
                .HAS_CNT (c == 1)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .wr_sel   (wr_sel),
                .wr_addr  (wr_data[AW-1:0]),
                .wr_cfg   (chan_cfg_t'(wr_data[CFG_W-1:0])),
                .ev_valid (ev_valid),
                .ev_addr  (ev_addr),
                .ev_kind  (ev_kind),
                .cfg      (cfg[c]),
                .hit      (hit[c])
            );
        end
    endgenerate

    seqbrk_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en && wr_sel == SEL_CNT),
        .load_val (wr_data[CNT_W-1:0]),
        .step     (hit[1] & cfg[1].cnt_en),
        .fire     (cnt_fire)
    );

    always_comb begin
        s_d = s_q;
        clr = (wr_en && wr_sel == SEL_CLR) ? wr_data[NCH-1:0] : '0;
        sat[0] = hit[0];
        sat[1] = hit[1] & (~cfg[1].cnt_en | cnt_fire);
        for (int c = 0; c < NCH; c++) begin
            link[c] = (cfg[c].chain_src != 1'(c))
                    & s_q.arm[cfg[c].chain_src]
                    & ~clr[cfg[c].chain_src];
            brk_ch[c] = sat[c] & cfg[c].brk_en & (~cfg[c].chain_en | link[c]);
        end
        s_d.flag = (s_q.flag & ~clr) | sat;
        // Armed once a flag has stayed set across one full edge.
        s_d.arm  = s_q.flag & s_d.flag;
        s_d.brk  = |brk_ch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign match_flag = s_q.flag;
    assign brk_req    = s_q.brk;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
                sat[c] |=> match_flag[c]);
            assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (match_flag[c] && !clr[c]) |=> match_flag[c]);
            assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[c] && !sat[c]) |=> !match_flag[c]);
            assert_arm_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(s_q.flag[c]) |-> !s_q.arm[c]);
        end
    endgenerate

    assert_brk_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat == '0) |=> !brk_req);

    assert_brk_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[0].brk_en && !cfg[1].brk_en) |=> !brk_req);

endmodule

// File: tb/seqbrk_unit_tb.sv
`timescale 1ns/1ps
module seqbrk_unit_tb;

    localparam int AW    = 12;
    localparam int CNT_W = 4;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic          ev_valid = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic          ev_kind = 1'b0;
    logic [1:0]    match_flag;
    logic          brk_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [AW-1:0] m_addr [2];
    bit            m_en [2], m_kind [2], m_ch [2], m_src [2], m_be [2];
    bit            m_ce;
    int            m_cnt;
    bit            m_flag [2];
    int            m_age [2];
    bit            m_brk;

    always #2 clk = ~clk;

    seqbrk_unit #(.AW(AW), .CNT_W(CNT_W), .DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ev_valid   (ev_valid),
        .ev_addr    (ev_addr),
        .ev_kind    (ev_kind),
        .match_flag (match_flag),
        .brk_req    (brk_req)
    );

    function automatic logic [DW-1:0] ctl(bit en, bit kind, bit ch, bit src, bit be, bit ce);
        return DW'({ce, be, src, ch, kind, en});
    endfunction

    task automatic model_update();
        bit h [2], s [2], cl [2], nf [2];
        bit nb = 1'b0;
        for (int c = 0; c < 2; c++) begin
            h[c]  = ev_valid && m_en[c] && ev_addr == m_addr[c] && ev_kind == m_kind[c];
            cl[c] = wr_en && wr_sel == 3'd5 && wr_data[c];
        end
        s[0] = h[0];
        s[1] = h[1] && (!m_ce || m_cnt == 1);
        for (int c = 0; c < 2; c++) begin
            int  o  = 1 - c;
            bit  ok = !m_ch[c] || (m_src[c] == o[0] && m_flag[o] && m_age[o] >= 1 && !cl[o]);
            if (s[c] && m_be[c] && ok) nb = 1'b1;
        end
        if (wr_en && wr_sel == 3'd4) m_cnt = int'(wr_data[CNT_W-1:0]);
        else if (h[1] && m_ce && m_cnt > 0) m_cnt = m_cnt - 1;
        for (int c = 0; c < 2; c++) begin
            nf[c] = (m_flag[c] && !cl[c]) || s[c];
            m_age[c] = (nf[c] && m_flag[c]) ? m_age[c] + 1 : 0;
            m_flag[c] = nf[c];
        end
        if (wr_en) begin
            case (wr_sel)
                3'd0: m_addr[0] = wr_data[AW-1:0];
                3'd2: m_addr[1] = wr_data[AW-1:0];
                3'd1, 3'd3: begin
                    int c = (wr_sel == 3'd1) ? 0 : 1;
                    m_en[c] = wr_data[0]; m_kind[c] = wr_data[1]; m_ch[c] = wr_data[2];
                    m_src[c] = wr_data[3]; m_be[c] = wr_data[4];
                    if (c == 1) m_ce = wr_data[5];
                end
                default: ;
            endcase
        end
        m_brk = nb;
    endtask

    task automatic step(input string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (match_flag !== {m_flag[1], m_flag[0]} || brk_req !== m_brk) begin
            errors++;
            $display("FAIL %s: flag=%b brk=%b expected flag=%b brk=%b",
                     tag, match_flag, brk_req, {m_flag[1], m_flag[0]}, m_brk);
        end
    endtask

    task automatic drive(input bit we, input logic [2:0] sel, input logic [DW-1:0] d,
                         input bit ev, input logic [AW-1:0] a, input bit k, input string tag);
        wr_en = we; wr_sel = sel; wr_data = d;
        ev_valid = ev; ev_addr = a; ev_kind = k;
        step(tag);
        wr_en = 1'b0; ev_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d, input string tag);
        drive(1'b1, sel, d, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic ev(input logic [AW-1:0] a, input bit k, input string tag);
        drive(1'b0, 3'd0, '0, 1'b1, a, k, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 3'd0, '0, 1'b0, '0, 1'b0, tag);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_addr[c] = '0; m_en[c] = 0; m_kind[c] = 0; m_ch[c] = 0; m_src[c] = 0;
            m_be[c] = 0; m_flag[c] = 0; m_age[c] = 0;
        end
        m_ce = 0; m_cnt = 0; m_brk = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (match_flag !== 2'b00 || brk_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: flag=%b brk=%b expected flag=00 brk=0", match_flag, brk_req);
        end
        ev(12'h000, 0, "R1 disabled channels ignore events");

        // Single channel, unchained
        wr(3'd1, ctl(1, 0, 0, 0, 1, 0), "R2 ch0 control");
        wr(3'd0, 16'h0100, "R2 ch0 address");
        ev(12'h100, 1, "R2 kind mismatch");
        ev(12'h101, 0, "R2 address mismatch");
        ev(12'h100, 0, "R5 unchained break");
        idle("R5 pulse one cycle");
        wr(3'd5, 16'h0001, "R4 clear");
        drive(1'b1, 3'd0, 16'h0200, 1'b1, 12'h200, 0, "R11 write and event same cycle");
        ev(12'h200, 0, "R11 new address active");
        drive(1'b1, 3'd5, 16'h0001, 1'b1, 12'h200, 0, "R4 match wins over clear");
        wr(3'd5, 16'h0003, "R4 clear both");

        // Chain 0 then 1, fetch/fetch
        wr(3'd0, 16'h0100, "R2 ch0 address");
        wr(3'd1, ctl(1, 0, 0, 0, 0, 0), "R6 ch0 first in chain");
        wr(3'd2, 16'h0300, "R2 ch1 address");
        wr(3'd3, ctl(1, 0, 1, 0, 1, 0), "R6 ch1 chained on ch0");
        ev(12'h300, 0, "R6 second alone no break");
        wr(3'd5, 16'h0003, "R4 clear");
        ev(12'h100, 0, "R3 first flag");
        ev(12'h300, 0, "R7 gap one no chain");
        wr(3'd5, 16'h0003, "R4 clear");
        ev(12'h100, 0, "R3 first flag");
        idle("R7 wait");
        ev(12'h300, 0, "R7 gap two chains");
        idle("R5 pulse ends");
        ev(12'h300, 0, "R6 rearmed rebreak");
        wr(3'd5, 16'h0003, "R4 clear");
        wr(3'd2, 16'h0100, "R7 identical addresses");
        ev(12'h100, 0, "R7 gap zero no chain");
        wr(3'd5, 16'h0003, "R4 clear");
        wr(3'd2, 16'h0300, "R2 ch1 address");

        // Disarm
        ev(12'h100, 0, "R8 arm");
        idle("R8 wait");
        idle("R8 wait");
        wr(3'd5, 16'h0001, "R8 disarm clear");
        ev(12'h300, 0, "R8 no break after clear");
        wr(3'd5, 16'h0003, "R4 clear");
        ev(12'h100, 0, "R8 arm");
        idle("R8 wait");
        idle("R8 wait");
        drive(1'b1, 3'd5, 16'h0001, 1'b1, 12'h300, 0, "R8 clear same cycle as second");
        wr(3'd5, 16'h0003, "R4 clear");

        // Chain 1 then 0, fetch then operand
        wr(3'd3, ctl(1, 0, 0, 0, 0, 0), "R6 ch1 first in chain");
        wr(3'd0, 16'h0080, "R2 ch0 address");
        wr(3'd1, ctl(1, 1, 1, 1, 1, 0), "R6 ch0 chained on ch1 operand");
        ev(12'h300, 0, "R6 reverse first");
        ev(12'h080, 1, "R7 operand gap one no chain");
        wr(3'd5, 16'h0003, "R4 clear");
        ev(12'h300, 0, "R6 reverse first");
        idle("R7 wait");
        ev(12'h080, 1, "R6 reverse order breaks");
        wr(3'd5, 16'h0003, "R4 clear");

        // Self-named source
        wr(3'd1, ctl(1, 1, 1, 0, 1, 0), "R10 ch0 source self");
        ev(12'h080, 1, "R10 first");
        idle("R10 wait");
        idle("R10 wait");
        ev(12'h080, 1, "R10 no break");
        wr(3'd5, 16'h0003, "R4 clear");

        // Counter on channel 1
        wr(3'd0, 16'h0100, "R2 ch0 address");
        wr(3'd1, ctl(1, 0, 0, 0, 0, 1), "R9 ch0 count bit ignored");
        wr(3'd3, ctl(1, 0, 1, 0, 1, 1), "R9 ch1 counted chain");
        wr(3'd4, 16'h0003, "R9 load three");
        ev(12'h100, 0, "R9 ch0 hits despite count bit");
        idle("R9 wait");
        ev(12'h300, 0, "R9 count three to two");
        ev(12'h300, 0, "R9 count two to one");
        ev(12'h300, 0, "R9 count reaches zero");
        ev(12'h300, 0, "R9 spent count");
        wr(3'd4, 16'h0001, "R9 load one");
        drive(1'b1, 3'd4, 16'h0002, 1'b1, 12'h300, 0, "R9 load wins old count fires");
        ev(12'h300, 0, "R9 reload two to one");
        ev(12'h300, 0, "R9 reload reaches zero");
        idle("R9 idle");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule